// File: doc/BRIEF.md
# Shared Sharing-Aware Victim Cache

This block is a last-level cache that four cores share, filled only with lines that their private second-level caches throw out. A core pushes an evicted line in through the insert port. Any core may then look the line up again by line address, whichever core inserted it. A lookup that misses raises a miss indication towards the memory side and allocates nothing.

On a hit the cache decides whether to keep its own copy. An instruction fetch always leaves the line resident. A data load keeps it only when the line has a history of use by more than one core. Otherwise the entry is dropped, so the line lives on only in the requester's private cache. Each way records the core that last inserted or requested it, and a sticky flag that is set as soon as a different core touches the line.

Each set holds 32 ways. Replacement is least recently used, and a freed way is always taken before any live line is evicted. A lookup takes two cycles, with the compare in the first and the response in the second. An insert always wins the state for its cycle: while an insert is present, a new lookup is held off, and a lookup already in flight waits one cycle.

Top module: `svc_cache`

## Requirements
- R1: After reset the block reports `lk_ready`=1, `rsp_valid`=0 and `miss_valid`=0, and every lookup misses.
- R2: A lookup miss gives `rsp_hit`=0 and, in the same cycle, `miss_valid`=1 with `miss_addr`/`miss_core` equal to the request. A miss allocates nothing, so repeating the lookup misses again.
- R3: An inserted line can be hit by any of the four cores, and `rsp_data` equals the data last inserted for that address.
- R4: A lookup with `lk_code`=1 (instruction fetch) that hits leaves the line resident, so the next lookup to that address hits.
- R5: A lookup with `lk_code`=0 (data load) that hits a line never shared drops the entry, and a later lookup to that address misses. A line is never shared when only the recording core has inserted or requested it.
- R6: A line counts as shared once any core other than the recorded one inserts or requests it, and the mark is sticky. A data-load hit on a shared line, counting the current request, keeps the line.
- R7: Inserting an address already present updates that entry in place with the new data, and no second copy is made.
- R8: A full set that receives a new line evicts its least recently used line. Inserts and hits that keep the line both count as uses.
- R9: A way freed by a data-load hit is reused before any live line is evicted.
- R10: A lookup accepted with no insert in the following cycle gives `rsp_valid`=1 exactly two cycles after acceptance, as a one-cycle pulse. `lk_ready` stays 0 while the lookup is in flight.
- R11: While `ins_valid`=1, `lk_ready` is 0. An insert in a lookup's compare cycle delays the response by one cycle, and that lookup sees the inserted line.
- R12: Reset is synchronous and drops every resident line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Victim insert strobe |
| ins_core | input | 2 | Core sending the victim |
| ins_addr | input | ADDR_W | Line address of the victim |
| ins_data | input | LINE_W | Victim line data |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_core | input | 2 | Requesting core |
| lk_addr | input | ADDR_W | Lookup line address |
| lk_code | input | 1 | 1 = instruction fetch, 0 = data load |
| rsp_valid | output | 1 | Lookup response pulse |
| rsp_hit | output | 1 | Response is a hit |
| rsp_data | output | LINE_W | Line data on a hit |
| miss_valid | output | 1 | Miss towards memory |
| miss_addr | output | ADDR_W | Address that missed |
| miss_core | output | 2 | Core that missed |

## Verification
A wrong owner or sharing flag shows up as a data-load hit that keeps a line it should drop, or drops a line it should keep. The error is visible on the very next lookup to that address, as a hit where a miss is due or the reverse. A wrong age order or a wrong choice of free way evicts the wrong line. That error stays hidden until a later lookup to the lost address, which can come many inserts later, so the bench overfills single sets and then probes every older address. Faults in the pipeline timing show up on `rsp_valid` and `lk_ready` within two or three cycles of the request.

// File: rtl/svc_pkg.sv
package svc_pkg;

    localparam int CORES  = 4;
    localparam int CORE_W = $clog2(CORES);
    localparam int WAYS   = 32;
    localparam int AGE_W  = $clog2(WAYS);

    typedef logic [CORE_W-1:0] core_t;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_CODE = 1'b1
    } kind_e;

    typedef struct packed {
        logic  valid;
        logic  shared;
        core_t owner;
    } meta_t;

    // Sharing history once the given core has touched the line.
    function automatic logic share_seen(meta_t m, core_t c);
        return m.shared | (m.owner != c);
    endfunction

    // Whether a hit of this kind leaves the line resident.
    function automatic logic retain_on_hit(kind_e k, logic sh);
        return (k == KIND_CODE) || sh;
    endfunction

endpackage

// File: rtl/svc_way_match.sv
module svc_way_match #(
    parameter int WAYS  = 32,
    parameter int TAG_W = 12,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [IDX_W-1:0]           way
);
    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |eq;
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (eq[i]) way = IDX_W'(i);
        end
    end
endmodule

// File: rtl/svc_victim_sel.sv
module svc_victim_sel #(
    parameter int WAYS  = 32,
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    output logic [AGE_W-1:0]           way
);
    logic [AGE_W-1:0] free_way;
    logic [AGE_W-1:0] old_way;
    logic             any_free;

    always_comb begin
        any_free = ~&vld;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) free_way = AGE_W'(i);
        end
        old_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (age[i] == AGE_W'(WAYS - 1)) old_way = AGE_W'(i);
        end
        way = any_free ? free_way : old_way;
    end
endmodule

// File: rtl/svc_age_touch.sv
module svc_age_touch #(
    parameter int WAYS  = 32,
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic [AGE_W-1:0]           used,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);
    logic [AGE_W-1:0] used_age;

    assign used_age = age_in[used];

    for (genvar g = 0; g < WAYS; g++) begin : g_age
        always_comb begin
            if (AGE_W'(g) == used)
                age_out[g] = '0;
            else if (age_in[g] < used_age)
                age_out[g] = age_in[g] + AGE_W'(1);
            else
                age_out[g] = age_in[g];
        end
    end
endmodule

// File: rtl/svc_cache.sv
module svc_cache
    import svc_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int ADDR_W = 16,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [1:0]        ins_core,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [LINE_W-1:0] ins_data,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [1:0]        lk_core,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_code,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              miss_valid,
    output logic [ADDR_W-1:0] miss_addr,
    output logic [1:0]        miss_core
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    // Line storage
    meta_t                       meta_q [SETS][WAYS];
    logic [TAG_W-1:0]            tag_q  [SETS][WAYS];
    logic [LINE_W-1:0]           data_q [SETS][WAYS];
    logic [WAYS-1:0][AGE_W-1:0]  age_q  [SETS];

    // Compare stage
    logic              s1_v;
    logic [ADDR_W-1:0] s1_addr;
    core_t             s1_core;
    kind_e             s1_kind;

    // Response stage
    logic              rsp_v_q;
    logic              rsp_hit_q;
    logic [LINE_W-1:0] rsp_data_q;
    logic [ADDR_W-1:0] rsp_addr_q;
    core_t             rsp_core_q;

    logic              accept, do_ins, do_cmp;
    logic [ADDR_W-1:0] sel_addr;
    logic [IDX_W-1:0]  sel_idx;
    logic [TAG_W-1:0]  sel_tag;
    core_t             req_core;

    logic [WAYS-1:0]             set_vld;
    logic [WAYS-1:0][TAG_W-1:0]  set_tag;
    logic [WAYS-1:0][AGE_W-1:0]  set_age;
    logic [WAYS-1:0][AGE_W-1:0]  age_next;
    logic                        hit;
    logic [AGE_W-1:0]            hit_way, vic_way, tgt_way;
    meta_t                       hit_meta;
    logic                        sh_new, keep;

    assign lk_ready = !s1_v && !ins_valid;
    assign accept   = lk_valid && lk_ready;
    assign do_ins   = ins_valid;
    assign do_cmp   = s1_v && !ins_valid;

    assign sel_addr = ins_valid ? ins_addr : s1_addr;
    assign sel_idx  = sel_addr[IDX_W-1:0];
    assign sel_tag  = sel_addr[ADDR_W-1:IDX_W];
    assign req_core = ins_valid ? core_t'(ins_core) : s1_core;
    assign set_age  = age_q[sel_idx];

    for (genvar g = 0; g < WAYS; g++) begin : g_set
        assign set_vld[g] = meta_q[sel_idx][g].valid;
        assign set_tag[g] = tag_q[sel_idx][g];
    end

    svc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .vld (set_vld),
        .tags(set_tag),
        .key (sel_tag),
        .hit (hit),
        .way (hit_way)
    );

    svc_victim_sel #(.WAYS(WAYS)) u_victim (
        .vld(set_vld),
        .age(set_age),
        .way(vic_way)
    );

    assign tgt_way = hit ? hit_way : vic_way;

    svc_age_touch #(.WAYS(WAYS)) u_age (
        .age_in (set_age),
        .used   (tgt_way),
        .age_out(age_next)
    );

    assign hit_meta = meta_q[sel_idx][hit_way];
    assign sh_new   = share_seen(hit_meta, req_core);
    assign keep     = retain_on_hit(s1_kind, sh_new);

    // Line state and recency
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    meta_q[s][w]   <= '0;
                    age_q[s][w]    <= AGE_W'(w);
                end
            end
        end else if (do_ins) begin
            meta_q[sel_idx][tgt_way] <= '{valid: 1'b1,
                                          shared: hit ? sh_new : 1'b0,
                                          owner: core_t'(ins_core)};
            age_q[sel_idx] <= age_next;
        end else if (do_cmp && hit) begin
            if (keep) begin
                meta_q[sel_idx][hit_way] <= '{valid: 1'b1, shared: sh_new,
                                              owner: s1_core};
                age_q[sel_idx] <= age_next;
            end else begin
                meta_q[sel_idx][hit_way].valid <= 1'b0;
            end
        end
    end

    // Tag and data arrays carry no reset
    always_ff @(posedge clk) begin
        if (do_ins) begin
            tag_q[sel_idx][tgt_way]  <= sel_tag;
            data_q[sel_idx][tgt_way] <= ins_data;
        end
    end

    // Request pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v      <= 1'b0;
            rsp_v_q   <= 1'b0;
            rsp_hit_q <= 1'b0;
        end else begin
            if (accept)      s1_v <= 1'b1;
            else if (do_cmp) s1_v <= 1'b0;
            rsp_v_q <= do_cmp;
            if (do_cmp) rsp_hit_q <= hit;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            s1_addr <= lk_addr;
            s1_core <= core_t'(lk_core);
            s1_kind <= kind_e'(lk_code);
        end
        if (do_cmp) begin
            rsp_data_q <= data_q[sel_idx][hit_way];
            rsp_addr_q <= s1_addr;
            rsp_core_q <= s1_core;
        end
    end

    assign rsp_valid  = rsp_v_q;
    assign rsp_hit    = rsp_v_q && rsp_hit_q;
    assign rsp_data   = rsp_data_q;
    assign miss_valid = rsp_v_q && !rsp_hit_q;
    assign miss_addr  = rsp_addr_q;
    assign miss_core  = rsp_core_q;

endmodule

// File: rtl/svc_cache_chk.sv
module svc_cache_chk (
    input logic clk,
    input logic rst,
    input logic ins_valid,
    input logic lk_valid,
    input logic lk_ready,
    input logic rsp_valid
);
    logic [1:0] inflight;

    always_ff @(posedge clk) begin
        if (rst)
            inflight <= '0;
        else
            inflight <= inflight + 2'(lk_valid && lk_ready) - 2'(rsp_valid);
    end

    p_ins_priority_r11: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> !lk_ready);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> (!lk_ready && !rsp_valid));

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) ##1 !ins_valid |=> rsp_valid);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_one_inflight_r10: assert property (@(posedge clk) disable iff (rst)
        inflight <= 2'd1);

    p_rsp_has_req_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> inflight == 2'd1);

endmodule

bind svc_cache svc_cache_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ins_valid(ins_valid),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .rsp_valid(rsp_valid)
);

// File: tb/svc_cache_tb.sv
module svc_cache_tb;
    localparam int SETS = 16;
    localparam int WAYS = 32;
    localparam int AW   = 16;
    localparam int LW   = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ins_valid = 1'b0;
    logic [1:0]    ins_core = '0;
    logic [AW-1:0] ins_addr = '0;
    logic [LW-1:0] ins_data = '0;
    logic          lk_valid = 1'b0;
    logic          lk_ready;
    logic [1:0]    lk_core = '0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_code = 1'b0;
    logic          rsp_valid, rsp_hit, miss_valid;
    logic [LW-1:0] rsp_data;
    logic [AW-1:0] miss_addr;
    logic [1:0]    miss_core;

    svc_cache u_dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model: per-set line list with use timestamps
    bit          m_v   [SETS][WAYS];
    logic [11:0] m_tag [SETS][WAYS];
    logic [31:0] m_dat [SETS][WAYS];
    logic [1:0]  m_own [SETS][WAYS];
    bit          m_sh  [SETS][WAYS];
    int          m_ts  [SETS][WAYS];
    int          tick = 0;

    function automatic logic [AW-1:0] mk(int s, int t);
        return {12'(t), 4'(s)};
    endfunction

    function automatic int m_find(logic [AW-1:0] a);
        for (int w = 0; w < WAYS; w++)
            if (m_v[a[3:0]][w] && m_tag[a[3:0]][w] == a[15:4]) return w;
        return -1;
    endfunction

    function automatic void m_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
    endfunction

    function automatic void m_insert(logic [1:0] c, logic [AW-1:0] a, logic [31:0] d);
        int s = int'(a[3:0]);
        int w = m_find(a);
        if (w >= 0) begin
            m_sh[s][w] = m_sh[s][w] || (m_own[s][w] != c);
        end else begin
            int best = -1;
            for (int i = 0; i < WAYS; i++)
                if (!m_v[s][i] && best < 0) best = i;
            if (best < 0) begin
                best = 0;
                for (int i = 1; i < WAYS; i++)
                    if (m_ts[s][i] < m_ts[s][best]) best = i;
            end
            w = best;
            m_sh[s][w] = 0;
        end
        m_v[s][w] = 1; m_tag[s][w] = a[15:4]; m_dat[s][w] = d;
        m_own[s][w] = c; tick++; m_ts[s][w] = tick;
    endfunction

    function automatic void m_lookup(logic [1:0] c, logic [AW-1:0] a, logic code,
                                     output logic h, output logic [31:0] d);
        int s = int'(a[3:0]);
        int w = m_find(a);
        h = (w >= 0); d = '0;
        if (h) begin
            bit sh = m_sh[s][w] || (m_own[s][w] != c);
            d = m_dat[s][w];
            if (code || sh) begin
                m_sh[s][w] = sh; m_own[s][w] = c; tick++; m_ts[s][w] = tick;
            end else begin
                m_v[s][w] = 0;
            end
        end
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string rq);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        m_clear();
    endtask

    task automatic do_insert(input logic [1:0] c, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        ins_valid = 1'b1; ins_core = c; ins_addr = a; ins_data = d;
        m_insert(c, a, d);
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [1:0] c, input logic [AW-1:0] a,
                             input logic code, input string rq);
        logic eh;
        logic [31:0] ed;
        m_lookup(c, a, code, eh, ed);
        @(negedge clk);
        lk_valid = 1'b1; lk_core = c; lk_addr = a; lk_code = code;
        chk(lk_ready, 1, "R10 ready when idle");
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        chk({lk_ready, rsp_valid}, 2'b00, "R10 busy after accept");
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid, 1, "R10 response at two cycles");
        chk(rsp_hit, eh, rq);
        if (eh) chk(rsp_data, ed, {rq, " data"});
        else begin
            chk(miss_valid, 1, "R2 miss flag");
            chk({miss_core, miss_addr}, {c, a}, "R2 miss address/core");
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ed;
        logic eh;
        void'($urandom(32'd2718));
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        chk({lk_ready, rsp_valid, miss_valid}, 3'b100, "R1 reset outputs");
        do_lookup(2'd0, mk(5, 1), 1'b1, "R1 empty after reset");
        // R2: miss does not fill
        do_lookup(2'd0, mk(5, 1), 1'b1, "R2 no fill on miss");

        // R3/R4: insert then instruction fetch keeps line
        do_insert(2'd0, mk(5, 1), 32'hA0A0_0001);
        do_lookup(2'd0, mk(5, 1), 1'b1, "R3 hit after insert");
        do_lookup(2'd0, mk(5, 1), 1'b1, "R4 code hit retained");

        // R5: unshared data load drops entry
        do_insert(2'd1, mk(5, 2), 32'hB0B0_0002);
        do_lookup(2'd1, mk(5, 2), 1'b0, "R5 data hit unshared");
        do_lookup(2'd1, mk(5, 2), 1'b1, "R5 dropped after data hit");

        // R6: cross-core request marks shared, and sticks
        do_insert(2'd2, mk(5, 3), 32'hC0C0_0003);
        do_lookup(2'd3, mk(5, 3), 1'b0, "R3 R6 other core data hit");
        do_lookup(2'd3, mk(5, 3), 1'b0, "R6 kept after shared data hit");
        do_lookup(2'd3, mk(5, 3), 1'b0, "R6 shared flag sticky");
        // R6/R7: insert by a second core marks shared and replaces data
        do_insert(2'd0, mk(5, 4), 32'hD0D0_0004);
        do_insert(2'd1, mk(5, 4), 32'hD1D1_0044);
        do_lookup(2'd1, mk(5, 4), 1'b0, "R6 R7 shared by insert");
        do_lookup(2'd1, mk(5, 4), 1'b0, "R6 still resident");

        // R7: in-place update, no second copy
        do_insert(2'd0, mk(6, 1), 32'hE000_0001);
        do_insert(2'd0, mk(6, 1), 32'hE000_0002);
        do_lookup(2'd0, mk(6, 1), 1'b0, "R7 newest data");
        do_lookup(2'd0, mk(6, 1), 1'b1, "R7 single copy");

        // R8: LRU eviction in a full set
        for (int t = 0; t < WAYS; t++) do_insert(2'd0, mk(7, t), 32'h7000_0000 + t);
        do_lookup(2'd0, mk(7, 0), 1'b1, "R8 refresh oldest");
        do_insert(2'd0, mk(7, 32), 32'h7000_0020);
        do_lookup(2'd0, mk(7, 1), 1'b1, "R8 LRU line evicted");
        do_lookup(2'd0, mk(7, 0), 1'b1, "R8 refreshed line kept");
        do_lookup(2'd0, mk(7, 32), 1'b1, "R8 new line present");

        // R9: freed way reused before eviction
        for (int t = 0; t < WAYS; t++) do_insert(2'd2, mk(8, t), 32'h8000_0000 + t);
        do_lookup(2'd2, mk(8, 5), 1'b0, "R9 free a way");
        do_insert(2'd2, mk(8, 40), 32'h8000_0040);
        for (int t = 0; t < WAYS; t++) do_lookup(2'd2, mk(8, t), 1'b1, "R9 no live line lost");
        do_lookup(2'd2, mk(8, 40), 1'b1, "R9 new line present");

        // R11: insert and lookup in the same cycle
        @(negedge clk);
        ins_valid = 1'b1; ins_core = 2'd3; ins_addr = mk(9, 1); ins_data = 32'h9000_0001;
        lk_valid = 1'b1; lk_core = 2'd1; lk_addr = mk(9, 1); lk_code = 1'b1;
        m_insert(2'd3, mk(9, 1), 32'h9000_0001);
        #1 chk(lk_ready, 0, "R11 lookup held by insert");
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        lk_valid = 1'b0;
        do_lookup(2'd1, mk(9, 1), 1'b1, "R11 lookup sees inserted line");

        // R11: insert during compare delays response one cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_core = 2'd0; lk_addr = mk(9, 2); lk_code = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        ins_valid = 1'b1; ins_core = 2'd2; ins_addr = mk(9, 2); ins_data = 32'h9000_0002;
        m_insert(2'd2, mk(9, 2), 32'h9000_0002);
        m_lookup(2'd0, mk(9, 2), 1'b1, eh, ed);
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        chk(rsp_valid, 0, "R11 response delayed");
        @(posedge clk);
        @(negedge clk);
        chk({rsp_valid, rsp_hit}, {1'b1, eh}, "R11 delayed response hits");
        chk(rsp_data, ed, "R11 delayed response data");

        // R12: reset drops all lines
        do_reset();
        chk({lk_ready, rsp_valid, miss_valid}, 3'b100, "R12 outputs after reset");
        do_lookup(2'd0, mk(5, 1), 1'b1, "R12 line gone after reset");
        do_lookup(2'd3, mk(5, 3), 1'b0, "R12 shared line gone");

        // Random mix over three sets with overflowing tag pool
        for (int i = 0; i < 700; i++) begin
            int s = int'($urandom_range(2, 0));
            int t = int'($urandom_range(39, 0));
            logic [1:0] c = 2'($urandom_range(3, 0));
            if ($urandom_range(99, 0) < 40)
                do_insert(c, mk(s, t), $urandom());
            else
                do_lookup(c, mk(s, t), 1'($urandom_range(1, 0)), "R3 R4 R5 R6 R8 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule